// File: doc/BRIEF.md
# Test-access port with gated in-system-programming commands

This block is the serial test-access port of a device. It runs the standard sixteen-state controller from the test clock and mode inputs. It keeps a 4-bit instruction register, a one-bit bypass register and a 32-bit identification register. From the active instruction it chooses which data register sits between the serial input and the serial output. The boundary-scan register and the programming shift register are outside the block. For those two, the block only gives select lines, the capture, shift and update phases, and takes their serial output bits back in.

The instruction set has the usual test instructions and four commands for in-system programming: enable, erase, program and verify. Erase, program and verify work only after an enable instruction has been loaded, and only if the controller has not passed through its reset state since then. When such a command is allowed, the block sends a one-cycle strobe to an external programming engine as the controller enters Run-Test/Idle. When it is not allowed, no strobe is sent and a sticky error flag is set. A high-impedance instruction raises an output-disable line for the system outputs.

Top module: `jtag_isp_tap`

## Requirements
- R1: The controller follows the standard 16-state diagram on rising `tck` edges. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. `trst` high (sampled on a rising edge) forces Test-Logic-Reset, and the instruction becomes 0001.
- R2: In Test-Logic-Reset the instruction becomes IDCODE (0001). With IDCODE, a 32-bit data scan shifts out the identification value, least significant bit first (default 0x1A5CE093).
- R3: Capture-IR loads 0001 into the instruction shift stage, so the first two bits shifted out of an instruction scan are 1 and then 0.
- R4: BYPASS (1111) and every undefined code select the one-bit bypass register. It captures 0, so a data scan returns the input delayed by one bit with a leading 0.
- R5: HIGHZ (0101) drives `out_disable` high and selects the bypass register. `out_disable` is low for every other code.
- R6: EXTEST (0000) and SAMPLE/PRELOAD (0010) raise `bsr_sel` and route `bsr_tdo` to `tdo`. `pins_preload` is high for EXTEST and for the four programming codes, and low for SAMPLE/PRELOAD and every other code.
- R7: ENABLE (1001), ERASE (1010), PROGRAM (1011) and VERIFY (1100) raise `isp_sel` and route `isp_tdo` to `tdo` during data scans.
- R8: ERASE, PROGRAM or VERIFY, once enabled, pulses `erase_stb`, `program_stb` or `verify_stb` for exactly one cycle: the first cycle in Run-Test/Idle after the controller enters it. At most one strobe is high at a time.
- R9: Loading ERASE, PROGRAM or VERIFY while the enable flag is clear gives no strobe and sets `isp_err`. `isp_err` then stays high until Test-Logic-Reset.
- R10: The enable flag, set by updating ENABLE, stays set across later instructions until Test-Logic-Reset. Test-Logic-Reset clears both the enable flag and `isp_err`.
- R11: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is high only during Shift-IR and Shift-DR.
- R12: `dr_capture`, `dr_shift` and `dr_update` are high exactly while the controller is in Capture-DR, Shift-DR and Update-DR, respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Active-high reset, synchronous to tck |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | High while tdo carries valid shift data |
| bsr_sel | output | 1 | Boundary-scan register selected |
| isp_sel | output | 1 | Programming shift register selected |
| dr_capture | output | 1 | Controller is in Capture-DR |
| dr_shift | output | 1 | Controller is in Shift-DR |
| dr_update | output | 1 | Controller is in Update-DR |
| bsr_tdo | input | 1 | Serial output of the external boundary-scan register |
| isp_tdo | input | 1 | Serial output of the external programming shift register |
| out_disable | output | 1 | Force all system outputs inactive |
| pins_preload | output | 1 | Pins driven from preloaded boundary values |
| erase_stb | output | 1 | One-cycle erase request |
| program_stb | output | 1 | One-cycle program request |
| verify_stb | output | 1 | One-cycle verify request |
| isp_err | output | 1 | Sticky flag: gated command issued without enable |

## Verification
If the controller state is wrong, it shows within one `tck` on the data-register phase outputs and on `tdo_oe`. Every rising edge is therefore compared with an independent state walk. If the instruction register is wrong, the select, disable and preload lines are wrong in the cycle after Update-IR, and a shifted-out instruction or data stream comes out with the wrong bits. If the enable or error flag is stale, this is only visible at the next gated command: it shows as a missing or extra strobe, or as `isp_err` not matching. For that reason, commands are issued before and after enable, and again after each route into Test-Logic-Reset.

// File: rtl/jtag_isp_pkg.sv
package jtag_isp_pkg;

  localparam int IR_W      = 4;
  localparam int RESET_RUN = 5;
  localparam int N_GATED   = 3;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_BSR, PATH_ISP} dr_path_e;

  typedef struct packed {
    dr_path_e path;
    logic     out_dis;
    logic     pin_hold;
  } ir_dec_t;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0010;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0101;
  localparam logic [IR_W-1:0] OP_ENABLE  = 4'b1001;
  localparam logic [IR_W-1:0] OP_ERASE   = 4'b1010;
  localparam logic [IR_W-1:0] OP_PROGRAM = 4'b1011;
  localparam logic [IR_W-1:0] OP_VERIFY  = 4'b1100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  function automatic logic [IR_W-1:0] gated_code(int idx);
    case (idx)
      0:       return OP_ERASE;
      1:       return OP_PROGRAM;
      default: return OP_VERIFY;
    endcase
  endfunction

  function automatic logic is_gated(logic [IR_W-1:0] c);
    return (c == OP_ERASE) || (c == OP_PROGRAM) || (c == OP_VERIFY);
  endfunction

  function automatic ir_dec_t decode_ir(logic [IR_W-1:0] c);
    ir_dec_t r;
    r.path     = PATH_BYP;
    r.out_dis  = 1'b0;
    r.pin_hold = 1'b0;
    case (c)
      OP_EXTEST: begin r.path = PATH_BSR; r.pin_hold = 1'b1; end
      OP_SAMPLE: r.path = PATH_BSR;
      OP_IDCODE: r.path = PATH_ID;
      OP_HIGHZ:  r.out_dis = 1'b1;
      OP_ENABLE, OP_ERASE, OP_PROGRAM, OP_VERIFY: begin
        r.path     = PATH_ISP;
        r.pin_hold = 1'b1;
      end
      default: r.path = PATH_BYP;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_isp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e state_nxt
);

  localparam int RUN_W = $clog2(RESET_RUN + 1);

  always_comb begin
    case (state)
      ST_RESET:    state_nxt = tms ? ST_RESET    : ST_IDLE;
      ST_IDLE:     state_nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   state_nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   state_nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: state_nxt = tms ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: state_nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: state_nxt = tms ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: state_nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   state_nxt = tms ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   state_nxt = tms ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   state_nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: state_nxt = tms ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: state_nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: state_nxt = tms ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: state_nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     state_nxt = tms ? ST_DR_SEL   : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= state_nxt;
  end

  // run length of consecutive high tms samples, used only by the check below
  logic [RUN_W-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst)                                     hi_run <= RUN_W'(RESET_RUN);
    else if (!tms)                               hi_run <= '0;
    else if (hi_run != RUN_W'(RESET_RUN))        hi_run <= hi_run + 1'b1;
  end

  // R1: five high tms edges always end in Test-Logic-Reset
  a_r1_five_high_reset: assert property (@(posedge clk) disable iff (rst)
    (hi_run == RUN_W'(RESET_RUN)) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_isp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic            ir_bit,
  output logic [IR_W-1:0] ir_nxt,
  output ir_dec_t         dec
);

  logic [IR_W-1:0] ir_sh;
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge clk) begin
    if (rst) ir_sh <= IR_CAPTURE;
    else if (state == ST_IR_CAP)   ir_sh <= IR_CAPTURE;
    else if (state == ST_IR_SHIFT) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
  end

  always_comb begin
    if (state == ST_RESET)       ir_nxt = OP_IDCODE;
    else if (state == ST_IR_UPD) ir_nxt = ir_sh;
    else                         ir_nxt = ir_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q <= OP_IDCODE;
      dec  <= decode_ir(OP_IDCODE);
    end else begin
      ir_q <= ir_nxt;
      dec  <= decode_ir(ir_nxt);
    end
  end

  assign ir_bit = ir_sh[0];

  // R3: capture pattern ends in 01
  a_r3_capture_pattern: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IR_CAP) |=> (ir_sh[1:0] == 2'b01));

  // R2: leaving reset the instruction is the identification one
  a_r2_reset_idcode: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESET) |=> (ir_q == OP_IDCODE));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_isp_pkg::*;
#(
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h1A5C_E093
)(
  input  logic       clk,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       byp_bit,
  output logic       id_bit
);

  logic [ID_W-1:0] id_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_bit <= 1'b0;
      id_sh   <= ID_VAL;
    end else if (state == ST_DR_CAP) begin
      byp_bit <= 1'b0;
      id_sh   <= ID_VAL;
    end else if (state == ST_DR_SHIFT) begin
      byp_bit <= tdi;
      id_sh   <= {tdi, id_sh[ID_W-1:1]};
    end
  end

  assign id_bit = id_sh[0];

  // R4: bypass stage captures zero
  a_r4_bypass_capture: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DR_CAP) |=> (byp_bit == 1'b0));

  // R2: identification register reloads on capture
  a_r2_id_capture: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DR_CAP) |=> (id_bit == ID_VAL[0]));

endmodule

// File: rtl/isp_gate.sv
module isp_gate
  import jtag_isp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  tap_state_e         state,
  input  tap_state_e         state_nxt,
  input  logic [IR_W-1:0]    ir_nxt,
  output logic [N_GATED-1:0] stb,
  output logic               err
);

  logic en_q;
  logic entering_idle;

  assign entering_idle = (state != ST_IDLE) && (state_nxt == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst || state == ST_RESET) begin
      en_q <= 1'b0;
      err  <= 1'b0;
    end else if (state == ST_IR_UPD) begin
      if (ir_nxt == OP_ENABLE)            en_q <= 1'b1;
      if (is_gated(ir_nxt) && !en_q)      err  <= 1'b1;
    end
  end

  for (genvar gi = 0; gi < N_GATED; gi++) begin : g_stb
    always_ff @(posedge clk) begin
      if (rst) stb[gi] <= 1'b0;
      else     stb[gi] <= entering_idle && en_q && (ir_nxt == gated_code(gi));
    end
  end

  // R8: never two strobes, each lasting one cycle, only while enabled
  a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb));
  a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
    (|stb) |=> !(|stb));
  a_r8_strobe_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (|stb) |-> en_q);
  // R9: error flag is sticky outside reset
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (err && state != ST_RESET) |=> err);
  // R10: Test-Logic-Reset clears both flags
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESET) |=> (!en_q && !err));

endmodule

// File: rtl/jtag_isp_tap.sv
module jtag_isp_tap
  import jtag_isp_pkg::*;
#(
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h1A5C_E093
)(
  input  logic tck,
  input  logic trst,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe,
  output logic bsr_sel,
  output logic isp_sel,
  output logic dr_capture,
  output logic dr_shift,
  output logic dr_update,
  input  logic bsr_tdo,
  input  logic isp_tdo,
  output logic out_disable,
  output logic pins_preload,
  output logic erase_stb,
  output logic program_stb,
  output logic verify_stb,
  output logic isp_err
);

  tap_state_e         state;
  tap_state_e         state_nxt;
  logic [IR_W-1:0]    ir_nxt;
  ir_dec_t            dec;
  logic               ir_bit;
  logic               byp_bit;
  logic               id_bit;
  logic [N_GATED-1:0] stb;
  logic               tdo_d;

  tap_fsm u_fsm (
    .clk(tck), .rst(trst), .tms(tms), .state(state), .state_nxt(state_nxt)
  );

  tap_ir u_ir (
    .clk(tck), .rst(trst), .state(state), .tdi(tdi),
    .ir_bit(ir_bit), .ir_nxt(ir_nxt), .dec(dec)
  );

  tap_dr #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
    .clk(tck), .rst(trst), .state(state), .tdi(tdi),
    .byp_bit(byp_bit), .id_bit(id_bit)
  );

  isp_gate u_gate (
    .clk(tck), .rst(trst), .state(state), .state_nxt(state_nxt),
    .ir_nxt(ir_nxt), .stb(stb), .err(isp_err)
  );

  always_comb begin
    tdo_d = 1'b0;
    if (state == ST_IR_SHIFT) begin
      tdo_d = ir_bit;
    end else if (state == ST_DR_SHIFT) begin
      case (dec.path)
        PATH_ID:  tdo_d = id_bit;
        PATH_BSR: tdo_d = bsr_tdo;
        PATH_ISP: tdo_d = isp_tdo;
        default:  tdo_d = byp_bit;
      endcase
    end
  end

  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_oe <= (state == ST_IR_SHIFT) || (state == ST_DR_SHIFT);
    end
  end

  assign bsr_sel      = (dec.path == PATH_BSR);
  assign isp_sel      = (dec.path == PATH_ISP);
  assign out_disable  = dec.out_dis;
  assign pins_preload = dec.pin_hold;
  assign dr_capture   = (state == ST_DR_CAP);
  assign dr_shift     = (state == ST_DR_SHIFT);
  assign dr_update    = (state == ST_DR_UPD);
  assign erase_stb    = stb[0];
  assign program_stb  = stb[1];
  assign verify_stb   = stb[2];

  // R11: output enable only during the two shift states
  a_r11_oe_in_shift: assert property (@(posedge tck) disable iff (trst)
    tdo_oe |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));
  // R5: disabled outputs never coincide with an external register path
  a_r5_highz_bypass: assert property (@(posedge tck) disable iff (trst)
    out_disable |-> (!bsr_sel && !isp_sel));
  // R12: phase outputs are mutually exclusive
  a_r12_phase_excl: assert property (@(posedge tck) disable iff (trst)
    $onehot0({dr_capture, dr_shift, dr_update}));

endmodule

// File: tb/jtag_isp_tap_test.sv
`timescale 1ns/1ps
module jtag_isp_tap_test;

  localparam logic [31:0] ID = 32'h1A5C_E093;
  localparam int M_TLR=0, M_RTI=1, M_SDR=2, M_CDR=3, M_SHD=4, M_E1D=5, M_PDR=6, M_E2D=7,
                 M_UDR=8, M_SIR=9, M_CIR=10, M_SHI=11, M_E1I=12, M_PIR=13, M_E2I=14, M_UIR=15;

  logic tck = 0, trst = 1, tms = 1, tdi = 1;
  logic bsr_tdo = 1'b1, isp_tdo = 1'b0;
  logic tdo, tdo_oe, bsr_sel, isp_sel, dr_capture, dr_shift, dr_update;
  logic out_disable, pins_preload, erase_stb, program_stb, verify_stb, isp_err;

  jtag_isp_tap uut (.*);

  always #2 tck = ~tck;

  int checks = 0, fails = 0;
  bit finished = 0;
  int ms;
  logic [3:0] mir, msh;
  logic [31:0] mid;
  logic mbyp, men, merr;
  logic [2:0] mstb;
  int n_erase = 0, n_prog = 0, n_ver = 0;
  bit was_shift = 0;
  logic last_o;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int mnext(int s, bit m);
    case (s)
      M_TLR: return m ? M_TLR : M_RTI;
      M_RTI: return m ? M_SDR : M_RTI;
      M_SDR: return m ? M_SIR : M_CDR;
      M_CDR: return m ? M_E1D : M_SHD;
      M_SHD: return m ? M_E1D : M_SHD;
      M_E1D: return m ? M_UDR : M_PDR;
      M_PDR: return m ? M_E2D : M_PDR;
      M_E2D: return m ? M_UDR : M_SHD;
      M_UDR: return m ? M_SDR : M_RTI;
      M_SIR: return m ? M_TLR : M_CIR;
      M_CIR: return m ? M_E1I : M_SHI;
      M_SHI: return m ? M_E1I : M_SHI;
      M_E1I: return m ? M_UIR : M_PIR;
      M_PIR: return m ? M_E2I : M_PIR;
      M_E2I: return m ? M_UIR : M_SHI;
      default: return m ? M_SDR : M_RTI;
    endcase
  endfunction

  // 0 bypass, 1 id, 2 boundary, 3 programming
  function automatic int mpath(logic [3:0] c);
    if (c == 4'b0000 || c == 4'b0010) return 2;
    if (c == 4'b0001) return 1;
    if (c >= 4'b1001 && c <= 4'b1100) return 3;
    return 0;
  endfunction

  function automatic bit mgated(logic [3:0] c);
    return c == 4'b1010 || c == 4'b1011 || c == 4'b1100;
  endfunction

  function automatic logic exp_tdo();
    if (ms == M_SHI) return msh[0];
    case (mpath(mir))
      1: return mid[0];
      2: return bsr_tdo;
      3: return isp_tdo;
      default: return mbyp;
    endcase
  endfunction

  task automatic model_reset();
    ms = M_TLR; mir = 4'b0001; men = 0; merr = 0; mstb = 0; mbyp = 0; mid = ID; msh = 4'b0001;
  endtask

  task automatic model_edge(bit m, bit d);
    logic [3:0] nir;
    int ns;
    ns  = mnext(ms, m);
    nir = (ms == M_TLR) ? 4'b0001 : (ms == M_UIR) ? msh : mir;
    mstb = 0;
    if (ms != M_RTI && ns == M_RTI && mgated(nir) && men)
      mstb = (nir == 4'b1010) ? 3'b001 : (nir == 4'b1011) ? 3'b010 : 3'b100;
    if (ms == M_TLR) begin men = 0; merr = 0; end
    else if (ms == M_UIR) begin
      if (nir == 4'b1001) men = 1;
      if (mgated(nir) && !men) merr = 1;
    end
    if (ms == M_CIR) msh = 4'b0001;
    else if (ms == M_SHI) msh = {d, msh[3:1]};
    if (ms == M_CDR) begin mbyp = 0; mid = ID; end
    else if (ms == M_SHD) begin mbyp = d; mid = {d, mid[31:1]}; end
    mir = nir;
    ms  = ns;
  endtask

  task automatic compare_outs();
    int p;
    p = mpath(mir);
    chk("R6 bsr_sel", bsr_sel, p == 2);
    chk("R7 isp_sel", isp_sel, p == 3);
    chk("R5 out_disable", out_disable, mir == 4'b0101);
    chk("R6 pins_preload", pins_preload, mir == 4'b0000 || p == 3);
    chk("R8 strobes", {verify_stb, program_stb, erase_stb}, mstb);
    chk("R9 isp_err", isp_err, merr);
    chk("R12 phases", {dr_capture, dr_shift, dr_update},
        {ms == M_CDR, ms == M_SHD, ms == M_UDR});
    if (was_shift) chk("R11 tdo held past rising edge", tdo, last_o);
    n_erase += erase_stb; n_prog += program_stb; n_ver += verify_stb;
  endtask

  task automatic step(input bit m, input bit d, output logic o);
    @(negedge tck); #1;
    o = tdo;
    was_shift = (ms == M_SHI || ms == M_SHD);
    last_o = o;
    chk("R11 tdo_oe", tdo_oe, was_shift);
    if (was_shift) chk("R11 tdo data", tdo, exp_tdo());
    tms = m; tdi = d;
    @(posedge tck);
    model_edge(m, d);
    #1;
    compare_outs();
  endtask

  task automatic do_reset();
    @(negedge tck); #1;
    trst = 1; tms = 1;
    @(posedge tck); @(posedge tck);
    model_reset();
    @(negedge tck); #1;
    trst = 0;
    was_shift = 0;
    compare_outs();
    chk("R1 tdo_oe after reset", tdo_oe, 0);
  endtask

  task automatic load_ir(input logic [3:0] code, output logic [3:0] outb);
    logic o;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i], o);
      outb[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
    logic o;
    dout = 0;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], o);
      dout[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] irb;
    logic [31:0] d;
    logic o;
    int e0, p0, v0;
    do_reset();
    chk("R1 reset out_disable", out_disable, 0);

    // R2: identification after reset
    step(0, 0, o);
    shift_dr(32, 32'h0, d);
    chk("R2 idcode shifted out", d, ID);

    // R3 and R4: all-ones instruction scan
    load_ir(4'b1111, irb);
    chk("R3 capture bits", irb[1:0], 2'b01);
    shift_dr(8, 32'h000000B2, d);
    chk("R4 bypass delay", d[7:0], 8'h64);

    load_ir(4'b0111, irb);
    shift_dr(5, 32'h00000013, d);
    chk("R4 undefined code as bypass", d[4:0], 5'b00110);

    // R5
    load_ir(4'b0101, irb);
    chk("R5 highz disable", out_disable, 1);
    shift_dr(4, 32'h0000000F, d);
    chk("R5 highz bypass", d[3:0], 4'b1110);

    // R6
    load_ir(4'b0000, irb);
    chk("R6 extest preload", pins_preload, 1);
    shift_dr(4, 32'h0, d);
    chk("R6 extest data from boundary", d[3:0], 4'hF);
    load_ir(4'b0010, irb);
    chk("R6 sample no preload", pins_preload, 0);
    chk("R6 sample selects boundary", bsr_sel, 1);

    // R9: gated without enable
    e0 = n_erase;
    load_ir(4'b1010, irb);
    chk("R9 no erase strobe", n_erase, e0);
    chk("R9 error set", isp_err, 1);
    load_ir(4'b0001, irb);
    chk("R9 error sticky", isp_err, 1);

    // R7
    load_ir(4'b1011, irb);
    chk("R7 isp select", isp_sel, 1);
    shift_dr(4, 32'hF, d);
    chk("R7 data from programming register", d[3:0], 4'h0);

    // R10: five high tms clear error
    for (int i = 0; i < 5; i++) step(1, 0, o);
    chk("R10 error cleared", isp_err, 0);
    step(0, 0, o);

    // R8 and R10: enabled commands persist
    e0 = n_erase; p0 = n_prog; v0 = n_ver;
    load_ir(4'b1001, irb);
    load_ir(4'b1010, irb);
    chk("R8 erase strobe", n_erase, e0 + 1);
    load_ir(4'b1011, irb);
    chk("R8 program strobe", n_prog, p0 + 1);
    load_ir(4'b0001, irb);
    load_ir(4'b1100, irb);
    chk("R10 enable persists verify", n_ver, v0 + 1);
    chk("R10 no error when enabled", isp_err, 0);

    // R1: five high tms from inside a data scan, then gated command fails
    step(1, 0, o); step(0, 0, o); step(0, 0, o); step(0, 1, o);
    for (int i = 0; i < 5; i++) step(1, 0, o);
    step(0, 0, o);
    shift_dr(32, 32'h0, d);
    chk("R1 reset from shift gives idcode", d, ID);
    p0 = n_prog;
    load_ir(4'b1011, irb);
    chk("R10 enable cleared by reset", n_prog, p0);
    chk("R10 error after reset", isp_err, 1);

    // R1: trst in the middle of a scan
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    do_reset();
    chk("R1 trst clears error", isp_err, 0);
    step(0, 0, o);
    shift_dr(32, 32'h0, d);
    chk("R1 idcode after trst", d, ID);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule